// File: doc/BRIEF.md
# SIMD Instruction Fault Checker

This block decides, before a packed-integer SIMD instruction executes, which single fault that instruction must raise, if any. It looks at the emulation, task-switched and OS-save-support control bits, the feature flag for the second-generation SIMD extension, a lock-prefix flag, the operand form (64-bit register form or 128-bit register form), the processor mode and the memory operand: its address, size, segment-limit result, stack-segment use and canonical form. Page faults, alignment-check faults and pending x87 exceptions are worked out elsewhere and come in as single flags that the block only gates and ranks.

Each request is marked by a one-cycle `in_valid` strobe. One cycle later `out_valid` pulses and `fault_vec` holds a one-hot code of the highest-priority fault, or zero when the instruction may proceed. The vector holds its value until the next request. The issue stage of a pipeline uses this result to pick the exception vector or to let the instruction proceed.

Top module: `simd_fault_check`

## Requirements
- R1: Invalid-opcode (fault_vec bit 0) is raised when `cr_emul` is 1, when `lock_pfx` is 1, when `feat_simd2` is 0, or when `wide_form` is 1 and `cr_osfx` is 0. With `wide_form` 0, `cr_osfx` has no effect.
- R2: Device-not-available (bit 1) is raised when `cr_task_sw` is 1.
- R3: Pending-x87 fault (bit 2) is raised from `x87_pend` only in the 64-bit form (`wide_form` 0). In the 128-bit form the flag has no effect.
- R4: In the 128-bit form with a memory operand (`has_mem` 1), an address that is not a multiple of 16 raises general-protection (bit 3) in every mode and for every segment. The check does not apply to the 64-bit form or when there is no memory operand.
- R5: Mode codes are 0 real, 1 virtual-8086, 2 protected, 3 compatibility and 4 64-bit. Codes 5 to 7 act as protected mode. In modes 0 and 1, a memory operand whose last byte (`eff_addr` + `acc_bytes` - 1) lies above FFFFH raises general-protection. Other modes do not apply this range check.
- R6: In protected, compatibility and reserved modes, `seg_limit_viol` with a memory operand raises stack fault (bit 4) when `via_stack` is 1 and general-protection otherwise. In modes 0, 1 and 4 the flag has no effect.
- R7: In 64-bit mode, a memory operand with `addr_canon` 0 raises stack fault when `via_stack` is 1 and general-protection otherwise. In other modes `addr_canon` has no effect.
- R8: Page fault (bit 5) passes through from `pf_in` when there is a memory operand. Alignment check (bit 6) passes through from `ac_in` only in the 64-bit form with a memory operand.
- R9: At most one bit of `fault_vec` is set. The priority from highest to lowest is invalid-opcode, device-not-available, pending-x87, general-protection, stack fault, page fault, alignment check.
- R10: `out_valid` is high exactly one cycle after `in_valid`. `fault_vec` changes only on the cycle after a request and holds otherwise. Synchronous `rst` clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| cr_emul | input | 1 | Emulation control bit |
| cr_task_sw | input | 1 | Task-switched control bit |
| cr_osfx | input | 1 | OS extended-state save support bit |
| feat_simd2 | input | 1 | SIMD extension feature flag |
| lock_pfx | input | 1 | Lock prefix present |
| wide_form | input | 1 | 1 = 128-bit form, 0 = 64-bit form |
| cpu_mode | input | 3 | Processor mode code (see R5) |
| has_mem | input | 1 | Instruction has a memory operand |
| eff_addr | input | ADDR_W | Effective address of the operand |
| acc_bytes | input | SIZE_W | Access size in bytes (1 to 16) |
| seg_limit_viol | input | 1 | Segment limit exceeded |
| via_stack | input | 1 | Access goes through the stack segment |
| addr_canon | input | 1 | Address is in canonical form |
| x87_pend | input | 1 | Pending x87 exception |
| pf_in | input | 1 | Page fault detected |
| ac_in | input | 1 | Alignment-check fault detected |
| out_valid | output | 1 | Result strobe |
| fault_vec | output | 7 | One-hot fault code (see R9) |

## Verification
The bench aims at the form-dependent gating: the OS-save bit, pending x87 and alignment check applied to the wrong form would raise a fault on instructions that are clean. It probes the real-mode range check at the last byte, with FFFFH inside and one past outside. An off-by-one there would fault on legal accesses or let a wrapped access through. It also crosses mode codes with the segment and canonical flags, so that a check leaking into the wrong mode shows up as a spurious fault. It stacks faults to expose a bad ranking, such as a stack fault reported over a misalignment.

// File: rtl/simd_flt_pkg.sv
package simd_flt_pkg;

    localparam int FAULT_N = 7;

    typedef enum logic [2:0] {
        MODE_REAL   = 3'd0,
        MODE_V86    = 3'd1,
        MODE_PROT   = 3'd2,
        MODE_COMPAT = 3'd3,
        MODE_LONG   = 3'd4
    } cpu_mode_e;

    // LSB first in priority: ud is bit 0, ac is bit 6
    typedef struct packed {
        logic ac;
        logic pf;
        logic ss;
        logic gp;
        logic mf;
        logic nm;
        logic ud;
    } fault_req_t;

    function automatic logic mode_is_rm(logic [2:0] m);
        return (m == MODE_REAL) || (m == MODE_V86);
    endfunction

    function automatic logic mode_is_seg(logic [2:0] m);
        return !mode_is_rm(m) && (m != MODE_LONG);
    endfunction

endpackage

// File: rtl/simd_flt_gate.sv
module simd_flt_gate (
    input  logic cr_emul,
    input  logic cr_task_sw,
    input  logic cr_osfx,
    input  logic feat_simd2,
    input  logic lock_pfx,
    input  logic wide_form,
    input  logic has_mem,
    input  logic x87_pend,
    input  logic pf_in,
    input  logic ac_in,
    output logic ud_o,
    output logic nm_o,
    output logic mf_o,
    output logic pf_o,
    output logic ac_o
);
    always_comb begin
        ud_o = cr_emul | lock_pfx | ~feat_simd2 | (wide_form & ~cr_osfx);
        nm_o = cr_task_sw;
        mf_o = ~wide_form & x87_pend;
        pf_o = has_mem & pf_in;
        ac_o = has_mem & ~wide_form & ac_in;
    end
endmodule

// File: rtl/simd_flt_mem.sv
module simd_flt_mem
    import simd_flt_pkg::*;
#(
    parameter int ADDR_W      = 48,
    parameter int SIZE_W      = 5,
    parameter int ALIGN_BYTES = 16,
    parameter int REAL_TOP    = 65535
) (
    input  logic              wide_form,
    input  logic [2:0]        cpu_mode,
    input  logic              has_mem,
    input  logic [ADDR_W-1:0] eff_addr,
    input  logic [SIZE_W-1:0] acc_bytes,
    input  logic              seg_limit_viol,
    input  logic              via_stack,
    input  logic              addr_canon,
    output logic              gp_o,
    output logic              ss_o
);
    localparam int ALIGN_LSB = $clog2(ALIGN_BYTES);
    localparam int AW1       = ADDR_W + 1;

    logic [SIZE_W-1:0] size_m1;
    logic [AW1-1:0]    last_byte;
    logic              misalign, over_top, seg_hit, nc_hit;

    always_comb begin
        size_m1   = (acc_bytes == '0) ? '0 : acc_bytes - 1'b1;
        last_byte = {1'b0, eff_addr} + AW1'(size_m1);
        misalign  = has_mem & wide_form & (eff_addr[ALIGN_LSB-1:0] != '0);
        over_top  = has_mem & mode_is_rm(cpu_mode) & (last_byte > AW1'(REAL_TOP));
        seg_hit   = has_mem & mode_is_seg(cpu_mode) & seg_limit_viol;
        nc_hit    = has_mem & (cpu_mode == MODE_LONG) & ~addr_canon;
        gp_o      = misalign | over_top | ((seg_hit | nc_hit) & ~via_stack);
        ss_o      = (seg_hit | nc_hit) & via_stack;
    end
endmodule

// File: rtl/simd_flt_prio.sv
module simd_flt_prio #(
    parameter int N = 7
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    logic [N-1:0] seen;

    assign seen[0] = 1'b0;
    generate
        for (genvar i = 1; i < N; i++) begin : g_seen
            assign seen[i] = seen[i-1] | req[i-1];
        end
        for (genvar i = 0; i < N; i++) begin : g_grant
            assign grant[i] = req[i] & ~seen[i];
        end
    endgenerate
endmodule

// File: rtl/simd_fault_check.sv
module simd_fault_check
    import simd_flt_pkg::*;
#(
    parameter int ADDR_W      = 48,
    parameter int SIZE_W      = 5,
    parameter int ALIGN_BYTES = 16,
    parameter int REAL_TOP    = 65535
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               cr_emul,
    input  logic               cr_task_sw,
    input  logic               cr_osfx,
    input  logic               feat_simd2,
    input  logic               lock_pfx,
    input  logic               wide_form,
    input  logic [2:0]         cpu_mode,
    input  logic               has_mem,
    input  logic [ADDR_W-1:0]  eff_addr,
    input  logic [SIZE_W-1:0]  acc_bytes,
    input  logic               seg_limit_viol,
    input  logic               via_stack,
    input  logic               addr_canon,
    input  logic               x87_pend,
    input  logic               pf_in,
    input  logic               ac_in,
    output logic               out_valid,
    output logic [FAULT_N-1:0] fault_vec
);
    fault_req_t         req;
    logic [FAULT_N-1:0] grant;
    logic               ud_w, nm_w, mf_w, pf_w, ac_w, gp_w, ss_w;

    simd_flt_gate u_gate (
        .cr_emul    (cr_emul),
        .cr_task_sw (cr_task_sw),
        .cr_osfx    (cr_osfx),
        .feat_simd2 (feat_simd2),
        .lock_pfx   (lock_pfx),
        .wide_form  (wide_form),
        .has_mem    (has_mem),
        .x87_pend   (x87_pend),
        .pf_in      (pf_in),
        .ac_in      (ac_in),
        .ud_o       (ud_w),
        .nm_o       (nm_w),
        .mf_o       (mf_w),
        .pf_o       (pf_w),
        .ac_o       (ac_w)
    );

    simd_flt_mem #(
        .ADDR_W      (ADDR_W),
        .SIZE_W      (SIZE_W),
        .ALIGN_BYTES (ALIGN_BYTES),
        .REAL_TOP    (REAL_TOP)
    ) u_mem (
        .wide_form      (wide_form),
        .cpu_mode       (cpu_mode),
        .has_mem        (has_mem),
        .eff_addr       (eff_addr),
        .acc_bytes      (acc_bytes),
        .seg_limit_viol (seg_limit_viol),
        .via_stack      (via_stack),
        .addr_canon     (addr_canon),
        .gp_o           (gp_w),
        .ss_o           (ss_w)
    );

    always_comb begin
        req.ud = ud_w;
        req.nm = nm_w;
        req.mf = mf_w;
        req.gp = gp_w;
        req.ss = ss_w;
        req.pf = pf_w;
        req.ac = ac_w;
    end

    simd_flt_prio #(.N(FAULT_N)) u_prio (
        .req   (req),
        .grant (grant)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            fault_vec <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                fault_vec <= grant;
            end
        end
    end
endmodule

// File: rtl/simd_fault_check_chk.sv
module simd_fault_check_chk #(
    parameter int ADDR_W      = 48,
    parameter int ALIGN_BYTES = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              cr_emul,
    input logic              cr_task_sw,
    input logic              cr_osfx,
    input logic              feat_simd2,
    input logic              lock_pfx,
    input logic              wide_form,
    input logic [2:0]        cpu_mode,
    input logic              has_mem,
    input logic [ADDR_W-1:0] eff_addr,
    input logic              addr_canon,
    input logic              via_stack,
    input logic              x87_pend,
    input logic              out_valid,
    input logic [6:0]        fault_vec
);
    localparam int ALIGN_LSB = $clog2(ALIGN_BYTES);

    logic no_ud;
    assign no_ud = !cr_emul && !lock_pfx && feat_simd2 && (!wide_form || cr_osfx);

    // R9
    onehot_fault_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fault_vec));

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R10
    valid_origin_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    // R10
    hold_vec_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(fault_vec));

    // R10
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (fault_vec == 7'd0 && !out_valid));

    // R1
    lock_ud_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && lock_pfx) |=> (fault_vec == 7'b0000001));

    // R2
    task_nm_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && no_ud && cr_task_sw) |=> (fault_vec == 7'b0000010));

    // R4
    misalign_gp_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && no_ud && !cr_task_sw && wide_form && has_mem
         && (eff_addr[ALIGN_LSB-1:0] != '0)) |=> (fault_vec == 7'b0001000));

    // R7
    long_ss_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && no_ud && !cr_task_sw && !wide_form && !x87_pend && has_mem
         && cpu_mode == 3'd4 && !addr_canon && via_stack) |=> (fault_vec == 7'b0010000));
endmodule

bind simd_fault_check simd_fault_check_chk #(
    .ADDR_W      (ADDR_W),
    .ALIGN_BYTES (ALIGN_BYTES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .cr_emul    (cr_emul),
    .cr_task_sw (cr_task_sw),
    .cr_osfx    (cr_osfx),
    .feat_simd2 (feat_simd2),
    .lock_pfx   (lock_pfx),
    .wide_form  (wide_form),
    .cpu_mode   (cpu_mode),
    .has_mem    (has_mem),
    .eff_addr   (eff_addr),
    .addr_canon (addr_canon),
    .via_stack  (via_stack),
    .x87_pend   (x87_pend),
    .out_valid  (out_valid),
    .fault_vec  (fault_vec)
);

// File: tb/simd_fault_check_bench.sv
`timescale 1ns/1ps
module simd_fault_check_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        cr_emul, cr_task_sw, cr_osfx, feat_simd2, lock_pfx, wide_form;
    logic [2:0]  cpu_mode;
    logic        has_mem;
    logic [47:0] eff_addr;
    logic [4:0]  acc_bytes;
    logic        seg_limit_viol, via_stack, addr_canon, x87_pend, pf_in, ac_in;
    logic        out_valid;
    logic [6:0]  fault_vec;

    int    n_chk = 0;
    int    n_err = 0;
    logic  started = 1'b0;
    logic  exp_valid;
    logic [6:0] exp_vec;
    string exp_tag = "R10";
    string cur_tag = "R10";

    always #2 clk = ~clk;

    simd_fault_check u_simd_fault_check (
        .clk(clk), .rst(rst), .in_valid(in_valid), .cr_emul(cr_emul),
        .cr_task_sw(cr_task_sw), .cr_osfx(cr_osfx), .feat_simd2(feat_simd2),
        .lock_pfx(lock_pfx), .wide_form(wide_form), .cpu_mode(cpu_mode),
        .has_mem(has_mem), .eff_addr(eff_addr), .acc_bytes(acc_bytes),
        .seg_limit_viol(seg_limit_viol), .via_stack(via_stack),
        .addr_canon(addr_canon), .x87_pend(x87_pend), .pf_in(pf_in),
        .ac_in(ac_in), .out_valid(out_valid), .fault_vec(fault_vec)
    );

    // Behavioural reference: walk the faults from most to least urgent.
    function automatic logic [6:0] model();
        longint last;
        logic   rm, seg, lng, gp, ss;
        last = longint'(eff_addr) + ((acc_bytes == 0) ? 0 : longint'(acc_bytes) - 1);
        rm   = (cpu_mode == 3'd0) || (cpu_mode == 3'd1);
        lng  = (cpu_mode == 3'd4);
        seg  = !rm && !lng;
        gp = 1'b0;
        ss = 1'b0;
        if (has_mem) begin
            if (wide_form && eff_addr[3:0] != 4'd0) gp = 1'b1;
            if (rm && last > 65535) gp = 1'b1;
            if ((seg && seg_limit_viol) || (lng && !addr_canon)) begin
                if (via_stack) ss = 1'b1; else gp = 1'b1;
            end
        end
        if (cr_emul || lock_pfx || !feat_simd2 || (wide_form && !cr_osfx)) return 7'b0000001;
        if (cr_task_sw) return 7'b0000010;
        if (!wide_form && x87_pend) return 7'b0000100;
        if (gp) return 7'b0001000;
        if (ss) return 7'b0010000;
        if (has_mem && pf_in) return 7'b0100000;
        if (has_mem && !wide_form && ac_in) return 7'b1000000;
        return 7'b0;
    endfunction

    function automatic string tag_for(logic [6:0] v);
        case (v)
            7'b0000001: return "R1";
            7'b0000010: return "R2";
            7'b0000100: return "R3";
            7'b0001000: return "R4";
            7'b0010000: return "R6";
            7'b0100000: return "R8";
            7'b1000000: return "R8";
            default:    return "R9";
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            exp_valid <= 1'b0;
            exp_vec   <= 7'd0;
            exp_tag   <= "R10";
            started   <= 1'b1;
        end else begin
            exp_valid <= in_valid;
            if (in_valid) begin
                exp_vec <= model();
                exp_tag <= cur_tag;
            end
        end
    end

    // Per-clock comparison against the reference model
    always @(negedge clk) begin
        if (started) begin
            n_chk++;
            if (out_valid !== exp_valid || fault_vec !== exp_vec) begin
                n_err++;
                $display("FAIL %s: out_valid=%0b fault_vec=%b expected out_valid=%0b fault_vec=%b",
                         exp_tag, out_valid, fault_vec, exp_valid, exp_vec);
            end
        end
    end

    task automatic clean();
        cr_emul = 0; cr_task_sw = 0; cr_osfx = 1; feat_simd2 = 1; lock_pfx = 0;
        wide_form = 1; cpu_mode = 3'd2; has_mem = 1; eff_addr = 48'h1000;
        acc_bytes = 5'd16; seg_limit_viol = 0; via_stack = 0; addr_canon = 1;
        x87_pend = 0; pf_in = 0; ac_in = 0;
    endtask

    task automatic narrow();
        wide_form = 0;
        acc_bytes = 5'd8;
    endtask

    // Directed request with an expected vector written by hand
    task automatic go(string tag, logic [6:0] exp);
        in_valid = 1'b1;
        cur_tag  = tag;
        @(negedge clk);
        in_valid = 1'b0;
        n_chk++;
        if (out_valid !== 1'b1 || fault_vec !== exp) begin
            n_err++;
            $display("FAIL %s: out_valid=%0b fault_vec=%b expected out_valid=1 fault_vec=%b",
                     tag, out_valid, fault_vec, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL R10: watchdog expired actual=hung expected=finished");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        clean();
        repeat (3) @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0 || fault_vec !== 7'd0) begin
            n_err++;
            $display("FAIL R10: reset out_valid=%0b fault_vec=%b expected 0 0000000", out_valid, fault_vec);
        end
        rst = 1'b0;
        @(negedge clk);

        clean(); go("R4", 7'b0000000);
        clean(); cr_emul = 1; go("R1", 7'b0000001);
        clean(); lock_pfx = 1; go("R1", 7'b0000001);
        clean(); feat_simd2 = 0; go("R1", 7'b0000001);
        clean(); cr_osfx = 0; go("R1", 7'b0000001);
        clean(); narrow(); cr_osfx = 0; go("R1", 7'b0000000);
        clean(); cr_task_sw = 1; go("R2", 7'b0000010);
        clean(); cr_task_sw = 1; lock_pfx = 1; go("R9", 7'b0000001);
        clean(); narrow(); x87_pend = 1; go("R3", 7'b0000100);
        clean(); x87_pend = 1; go("R3", 7'b0000000);
        clean(); narrow(); x87_pend = 1; cr_task_sw = 1; go("R9", 7'b0000010);
        clean(); eff_addr = 48'h1008; go("R4", 7'b0001000);
        clean(); narrow(); eff_addr = 48'h1004; go("R4", 7'b0000000);
        clean(); eff_addr = 48'h1008; has_mem = 0; go("R4", 7'b0000000);
        clean(); cpu_mode = 3'd4; eff_addr = 48'h1001; go("R4", 7'b0001000);
        clean(); cpu_mode = 3'd0; eff_addr = 48'hFFF0; go("R5", 7'b0000000);
        clean(); narrow(); cpu_mode = 3'd0; eff_addr = 48'hFFF8; go("R5", 7'b0000000);
        clean(); narrow(); cpu_mode = 3'd0; eff_addr = 48'hFFF9; go("R5", 7'b0001000);
        clean(); narrow(); cpu_mode = 3'd1; eff_addr = 48'h10000; go("R5", 7'b0001000);
        clean(); narrow(); cpu_mode = 3'd2; eff_addr = 48'h20000; go("R5", 7'b0000000);
        clean(); cpu_mode = 3'd0; seg_limit_viol = 1; go("R6", 7'b0000000);
        clean(); seg_limit_viol = 1; go("R6", 7'b0001000);
        clean(); seg_limit_viol = 1; via_stack = 1; go("R6", 7'b0010000);
        clean(); cpu_mode = 3'd3; seg_limit_viol = 1; via_stack = 1; go("R6", 7'b0010000);
        clean(); cpu_mode = 3'd6; seg_limit_viol = 1; go("R6", 7'b0001000);
        clean(); cpu_mode = 3'd4; seg_limit_viol = 1; go("R6", 7'b0000000);
        clean(); cpu_mode = 3'd4; addr_canon = 0; go("R7", 7'b0001000);
        clean(); cpu_mode = 3'd4; addr_canon = 0; via_stack = 1; go("R7", 7'b0010000);
        clean(); addr_canon = 0; via_stack = 1; go("R7", 7'b0000000);
        clean(); cpu_mode = 3'd4; addr_canon = 0; via_stack = 1; eff_addr = 48'h1004; go("R9", 7'b0001000);
        clean(); pf_in = 1; go("R8", 7'b0100000);
        clean(); pf_in = 1; has_mem = 0; go("R8", 7'b0000000);
        clean(); narrow(); ac_in = 1; go("R8", 7'b1000000);
        clean(); ac_in = 1; go("R8", 7'b0000000);
        clean(); narrow(); ac_in = 1; pf_in = 1; go("R9", 7'b0100000);
        clean(); seg_limit_viol = 1; pf_in = 1; go("R9", 7'b0001000);

        // R10: vector holds while idle, inputs changing
        clean(); lock_pfx = 1; go("R10", 7'b0000001);
        clean(); cr_task_sw = 1;
        repeat (3) @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0 || fault_vec !== 7'b0000001) begin
            n_err++;
            $display("FAIL R10: idle out_valid=%0b fault_vec=%b expected 0 0000001", out_valid, fault_vec);
        end
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        n_chk++;
        if (out_valid !== 1'b0 || fault_vec !== 7'd0) begin
            n_err++;
            $display("FAIL R10: after reset out_valid=%0b fault_vec=%b expected 0 0000000", out_valid, fault_vec);
        end

        // Mixed stimulus, compared every clock against the model
        for (int i = 0; i < 4000; i++) begin
            cr_emul        = ($urandom % 16) == 0;
            cr_task_sw     = ($urandom % 12) == 0;
            cr_osfx        = ($urandom % 12) != 0;
            feat_simd2     = ($urandom % 16) != 0;
            lock_pfx       = ($urandom % 16) == 0;
            wide_form      = $urandom % 2;
            cpu_mode       = 3'($urandom % 8);
            has_mem        = ($urandom % 4) != 0;
            case ($urandom % 3)
                0:       eff_addr = 48'hFFE0 + 48'($urandom % 48);
                1:       eff_addr = {32'd0, 12'($urandom), 4'd0};
                default: eff_addr = {16'($urandom), 32'($urandom)};
            endcase
            acc_bytes      = wide_form ? 5'd16 : 5'd8;
            seg_limit_viol = ($urandom % 6) == 0;
            via_stack      = $urandom % 2;
            addr_canon     = ($urandom % 5) != 0;
            x87_pend       = ($urandom % 6) == 0;
            pf_in          = ($urandom % 6) == 0;
            ac_in          = ($urandom % 6) == 0;
            cur_tag        = tag_for(model());
            in_valid       = ($urandom % 4) != 0;
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (2) @(negedge clk);

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule